// File: doc/BRIEF.md
# Table-Driven Video Timing Generator

This block produces the horizontal sync, vertical sync and blanking strobes for a raster display. It does not compare counters against fixed constants. A pair of X/Y scan counters addresses a small writable timing table, and each table entry is a 5-bit control word. The word is registered and driven straight to the outputs. The same word also holds a line-end strobe and a frame-end strobe. These strobes steer the block's own counters and are also passed out, so that frame-buffer scan counters elsewhere can follow the same raster.

After power-up a host fills the table through a dedicated write port while the block is disabled. Raising the enable starts scanning from the top-left position. To select another video format, disable the block, rewrite the table and enable it again; no logic changes. The counter widths are parameters. The table has one entry for every X/Y position.

Top module: `vid_timing_gen`

## Requirements
- R1: While rst_ni is low, all five outputs are 0.
- R2: While en_i is low, the next clock edge drives all outputs to 0 and returns the scan counters to position (0,0).
- R3: When en_i is low and wr_en_i is high at a clock edge, wr_data_i is stored at entry wr_addr_i. The entry address is y*2^X_W + x. Data bit 0 is hsync, bit 1 vsync, bit 2 blank, bit 3 line-end (xwrap), and bit 4 frame-end (yreset).
- R4: Writes presented while en_i is high leave the table unchanged.
- R5: While enabled, the outputs at each edge equal the table word of the position the counters held just before that edge. The first enabled edge presents the word of position (0,0).
- R6: When the current word has its line-end bit clear, x advances by one and y holds. x rolls over naturally at 2^X_W.
- R7: When the current word has its line-end bit set and its frame-end bit clear, x returns to 0 and y advances by one.
- R8: When the current word has both the line-end and frame-end bits set, x and y both return to 0.
- R9: A frame-end bit without the line-end bit has no effect on the counters, but it still appears on yreset_o.
- R10: Dropping en_i in the middle of a frame and raising it again restarts the scan at (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Scan enable; the table is writable only while this is low |
| wr_en_i | input | 1 | Host table write strobe |
| wr_addr_i | input | X_W+Y_W | Host table entry address {y,x} |
| wr_data_i | input | 5 | Host table word {yreset, xwrap, blank, vsync, hsync} |
| hsync_o | output | 1 | Horizontal sync from the table |
| vsync_o | output | 1 | Vertical sync from the table |
| blank_o | output | 1 | Blanking from the table |
| xwrap_o | output | 1 | Line-end strobe for the frame-buffer counters |
| yreset_o | output | 1 | Frame-end strobe for the frame-buffer counters |

## Verification
Each output word is due exactly one clock edge after the counters reach its position. The counters move at that same edge, so the word for position (x,y) is visible during the cycle after the counters held (x,y). A host write lands in the table at the edge where it is presented. Dropping the enable clears the outputs at the very next edge. The bench drives each input set just after a falling edge and pushes the expected word for the following rising edge into a queue. A monitor samples 3 ns after that rising edge, pops one entry and compares it, so every comparison falls in the single cycle when its result is due.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CW = 5;

  typedef struct packed {
    logic yreset;
    logic xwrap;
    logic blank;
    logic vsync;
    logic hsync;
  } ctrl_t;
endpackage

// File: rtl/vtg_table.sv
module vtg_table
  import vtg_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  ctrl_t         wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output ctrl_t         rd_word_o
);
  localparam int DEPTH = 1 << AW;

  ctrl_t mem_q [DEPTH];
  logic  wr_ok;

  // host path only live while scanning is stopped
  assign wr_ok = wr_en_i && !en_i;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_word_o = mem_q[rd_addr_i];

  p_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_en_i) |=> (mem_q[$past(wr_addr_i)] == $past(mem_q[wr_addr_i])))
    else $error("table written while enabled");
endmodule

// File: rtl/vtg_scan_cnt.sv
module vtg_scan_cnt #(
  parameter int X_W = 5,
  parameter int Y_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           xwrap_i,
  input  logic           yreset_i,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o
);
  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (!en_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (xwrap_i) begin
      x_q <= '0;
      y_q <= yreset_i ? '0 : y_q + Y_W'(1);
    end else begin
      x_q <= x_q + X_W'(1);
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (x_q == '0 && y_q == '0))
    else $error("counters not parked");

  // covers R9 too: yreset alone must not disturb y
  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !xwrap_i) |=> (x_q == X_W'($past(x_q) + X_W'(1)) && y_q == $past(y_q)))
    else $error("x step wrong");

  p_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && xwrap_i && !yreset_i) |=> (x_q == '0 && y_q == Y_W'($past(y_q) + Y_W'(1))))
    else $error("line wrap wrong");

  p_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && xwrap_i && yreset_i) |=> (x_q == '0 && y_q == '0))
    else $error("frame wrap wrong");
endmodule

// File: rtl/vtg_out_reg.sv
module vtg_out_reg
  import vtg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  ctrl_t word_i,
  output ctrl_t word_o
);
  ctrl_t word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= '0;
    else if (!en_i) word_q <= '0;
    else            word_q <= word_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int X_W = 5,
  parameter int Y_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               wr_en_i,
  input  logic [X_W+Y_W-1:0] wr_addr_i,
  input  logic [CW-1:0]      wr_data_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               blank_o,
  output logic               xwrap_o,
  output logic               yreset_o
);
  localparam int AW = X_W + Y_W;

  logic [X_W-1:0] x;
  logic [Y_W-1:0] y;
  ctrl_t          raw_word;
  ctrl_t          out_word;

  vtg_table #(.AW(AW)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (ctrl_t'(wr_data_i)),
    .rd_addr_i ({y, x}),
    .rd_word_o (raw_word)
  );

  vtg_scan_cnt #(.X_W(X_W), .Y_W(Y_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .xwrap_i  (raw_word.xwrap),
    .yreset_i (raw_word.yreset),
    .x_o      (x),
    .y_o      (y)
  );

  vtg_out_reg u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .word_i (raw_word),
    .word_o (out_word)
  );

  assign hsync_o  = out_word.hsync;
  assign vsync_o  = out_word.vsync;
  assign blank_o  = out_word.blank;
  assign xwrap_o  = out_word.xwrap;
  assign yreset_o = out_word.yreset;

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(hsync_o || vsync_o || blank_o || xwrap_o || yreset_o))
    else $error("outputs active while disabled");
endmodule

// File: tb/vid_timing_gen_test.sv
module vid_timing_gen_test;
  localparam int XW = 3;
  localparam int YW = 2;
  localparam int AW = XW + YW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] wa = '0;
  logic [4:0] wd = '0;
  logic hs, vs, bl, xw, yr;

  always #5 clk = ~clk;

  vid_timing_gen #(.X_W(XW), .Y_W(YW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .wr_en_i(we),
    .wr_addr_i(wa), .wr_data_i(wd),
    .hsync_o(hs), .vsync_o(vs), .blank_o(bl), .xwrap_o(xw), .yreset_o(yr)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [4:0] mem_m [DEPTH];
  logic [XW-1:0] mx = '0;
  logic [YW-1:0] my = '0;
  logic [4:0] prev_w = '0;
  string ovr = "";
  logic [4:0] exp_q [$];
  string tag_q [$];

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // one driven cycle; expectation follows R2..R10
  task automatic step(bit e, bit w, int a, logic [4:0] d);
    logic [4:0] ex;
    logic [4:0] cur;
    string t;
    @(negedge clk);
    en = e; we = w; wa = a[AW-1:0]; wd = d;
    if (!e) begin
      ex = '0;
      t = "R2";
      if (w) mem_m[a] = d;
      mx = '0; my = '0; prev_w = '0;
    end else begin
      cur = mem_m[{my, mx}];
      ex = cur;
      if (prev_w[3] && prev_w[4]) t = "R8";
      else if (prev_w[3])         t = "R7";
      else if (prev_w[4])         t = "R9";
      else                        t = "R6";
      if (ovr != "") t = ovr;
      if (cur[3]) begin
        mx = '0;
        my = cur[4] ? '0 : my + 1'b1;
      end else begin
        mx = mx + 1'b1;
      end
      prev_w = cur;
    end
    exp_q.push_back(ex);
    tag_q.push_back(t);
  endtask

  // width 6, 3 lines
  function automatic logic [4:0] fmt_a(int x, int y);
    logic [4:0] r;
    if (x > 5 || y > 2) return '0;
    r[0] = (x == 3 || x == 4);
    r[1] = (y == 1);
    r[2] = (x >= 4 || y == 2);
    r[3] = (x == 5);
    r[4] = (x == 5 && y == 2);
    return r;
  endfunction

  // width 4, 2 lines, lone frame-end bit at (1,0)
  function automatic logic [4:0] fmt_b(int x, int y);
    logic [4:0] r;
    if (x > 3 || y > 1) return '0;
    r[0] = (x == 0);
    r[1] = (y == 0);
    r[2] = (x == 3);
    r[3] = (x == 3);
    r[4] = (x == 3 && y == 1) || (x == 1 && y == 0);
    return r;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_q.size() > 0) check(tag_q.pop_front(), {yr, xw, bl, vs, hs}, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #3;
    check("R1", {yr, xw, bl, vs, hs}, 5'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int a = 0; a < DEPTH; a++) step(0, 1, a, fmt_a(a % 8, a / 8));

    ovr = "R3";
    for (int i = 0; i < 18; i++) step(1, 0, 0, '0);
    ovr = "";
    for (int i = 0; i < 36; i++) step(1, 0, 0, '0);

    // attempted overwrite while scanning
    for (int i = 0; i < 18; i++) step(1, 1, i, ~fmt_a(i % 8, i / 8));
    ovr = "R4";
    for (int i = 0; i < 18; i++) step(1, 0, 0, '0);
    ovr = "";

    for (int i = 0; i < 7; i++) step(1, 0, 0, '0);
    step(0, 0, 0, '0);
    step(0, 0, 0, '0);
    ovr = "R10";
    for (int i = 0; i < 5; i++) step(1, 0, 0, '0);
    ovr = "";
    for (int i = 0; i < 13; i++) step(1, 0, 0, '0);

    for (int a = 0; a < DEPTH; a++) step(0, 1, a, fmt_b(a % 8, a / 8));
    ovr = "R5";
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0);
    ovr = "";
    for (int i = 0; i < 21; i++) step(1, 0, 0, '0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule